// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a 16-bit processor bus and a small flash store. Software drives it with one-word commands and two-word command sequences. The command byte is always the low byte of the written word. One-word commands choose what later reads return: either the stored array words or the status register. Another one-word command clears the error flags. Two-word sequences start a program operation or a block erase. The store is a behavioural model that takes a fixed number of cycles for each operation, then reports completion to the sequencer.

While an operation is in progress, the status register shows the block as not ready and the sequencer ignores every write. When the operation ends, the sequencer stays in status-read mode so that software can keep polling the status register. If an erase is started but its second word is not the confirm code, nothing is erased and the error flags record a sequence fault. Writes to odd byte addresses are discarded. Read data appears on `bus_rdata` one cycle after a read strobe.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode, the status byte is 0x80 (ready set, both error flags clear), and every stored word reads 0xFFFF.
- R2: Only bits 7:0 of a written word are decoded as a command, so bits 15:8 have no effect on which command is taken.
- R3: After the command 0xFF, each read strobe returns, on the next cycle, the stored word at index `bus_addr[ADDR_W-1:1]`, until another command is accepted.
- R4: After the command 0x70, each read returns {8'h00, status byte} whatever the address. The status byte holds ready in bit 7, the erase-error flag in bit 5 and the program-error flag in bit 4; all other bits are 0.
- R5: The command 0x50 clears both error flags in the cycle it is written and leaves the read mode unchanged.
- R6: The command 0x40 followed by a write of word D to even address A replaces the stored word at A with (old AND D).
- R7: The command 0x20 followed by a write of 0xD0 to an even address sets every word of that address's block (2**BLK_LOG words) to 0xFFFF. Other blocks are left unchanged.
- R8: The command 0x20 followed by any even write whose low byte is not 0xD0 erases nothing, sets both error flags and enters status-read mode.
- R9: From the accepted second word of a program or erase until the store signals completion, the ready bit reads 0 and all writes are ignored.
- R10: When an operation completes, ready returns to 1 and the block stays in status-read mode.
- R11: Writes to odd byte addresses change neither the read mode, nor the sequence state, nor the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 16 | Write data or command word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |

## Verification
The assertions assume that each bus write lasts exactly one cycle and that the read and write strobes never fire together. They also assume that an accepted program or erase write is followed by a finished operation before the block is reset again. The bench holds each strobe for a single cycle, never overlaps reads and writes, and ends every operation by polling status until ready returns. It sweeps all 256 command bytes with scrambled high bytes and programs every word of the store. It also erases blocks through both the confirm path and the abort path, with odd-address writes placed in the middle of sequences.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR_ERR   = 8'h50;
    localparam logic [7:0] CMD_PROGRAM     = 8'h40;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PROG_ARM,
        SQ_ERASE_ARM,
        SQ_BUSY
    } seq_state_t;

    typedef enum logic {
        RM_ARRAY,
        RM_STATUS
    } read_mode_t;

    typedef enum logic {
        OP_PROGRAM,
        OP_ERASE
    } flash_op_t;

    typedef struct packed {
        logic ready;
        logic erase_err;
        logic prog_err;
    } status_t;

    function automatic logic [7:0] status_byte(status_t s);
        return {s.ready, 1'b0, s.erase_err, s.prog_err, 4'b0000};
    endfunction

endpackage

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int BLK_LOG   = 3,
    parameter int OP_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  flash_op_t        req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [15:0]      req_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_word,
    output logic             op_done
);
    localparam int WORDS = 1 << IDX_W;
    localparam int CNT_W = $clog2(OP_CYCLES + 1);

    logic [15:0]      mem [WORDS];
    logic [CNT_W-1:0] cnt_q;
    flash_op_t        op_q;
    logic [IDX_W-1:0] idx_q;
    logic [15:0]      data_q;

    assign op_done = (cnt_q == CNT_W'(1));
    assign rd_word = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            op_q   <= OP_PROGRAM;
            idx_q  <= '0;
            data_q <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
        end else if (req_valid) begin
            cnt_q  <= CNT_W'(OP_CYCLES);
            op_q   <= req_op;
            idx_q  <= req_idx;
            data_q <= req_data;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (op_done) begin
                if (op_q == OP_PROGRAM) begin
                    mem[idx_q] <= mem[idx_q] & data_q;
                end else begin
                    for (int i = 0; i < WORDS; i++) begin
                        if ((IDX_W'(i) >> BLK_LOG) == (idx_q >> BLK_LOG))
                            mem[i] <= 16'hFFFF;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fcs_status.sv
module fcs_status
    import fcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  logic    clear_err,
    input  logic    seq_err,
    output status_t st
);
    logic erase_err_q;
    logic prog_err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            erase_err_q <= 1'b0;
            prog_err_q  <= 1'b0;
        end else if (clear_err) begin
            erase_err_q <= 1'b0;
            prog_err_q  <= 1'b0;
        end else if (seq_err) begin
            erase_err_q <= 1'b1;
            prog_err_q  <= 1'b1;
        end
    end

    assign st = '{ready: !busy, erase_err: erase_err_q, prog_err: prog_err_q};
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
    import fcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic        addr_even,
    input  logic [7:0]  cmd,
    input  logic        op_done,
    output seq_state_t  state,
    output read_mode_t  mode,
    output logic        req_valid,
    output flash_op_t   req_op,
    output logic        clear_err,
    output logic        seq_err
);
    logic accept;

    assign accept    = wr && addr_even;
    assign req_valid = accept && ((state == SQ_PROG_ARM) ||
                                  (state == SQ_ERASE_ARM && cmd == CMD_CONFIRM));
    assign req_op    = (state == SQ_ERASE_ARM) ? OP_ERASE : OP_PROGRAM;
    assign clear_err = accept && state == SQ_IDLE && cmd == CMD_CLEAR_ERR;
    assign seq_err   = accept && state == SQ_ERASE_ARM && cmd != CMD_CONFIRM;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            mode  <= RM_ARRAY;
        end else begin
            unique case (state)
                SQ_IDLE: if (accept) begin
                    case (cmd)
                        CMD_READ_ARRAY:  mode  <= RM_ARRAY;
                        CMD_READ_STATUS: mode  <= RM_STATUS;
                        CMD_PROGRAM:     state <= SQ_PROG_ARM;
                        CMD_ERASE:       state <= SQ_ERASE_ARM;
                        default: ;
                    endcase
                end
                SQ_PROG_ARM: if (accept) begin
                    state <= SQ_BUSY;
                    mode  <= RM_STATUS;
                end
                SQ_ERASE_ARM: if (accept) begin
                    mode  <= RM_STATUS;
                    state <= (cmd == CMD_CONFIRM) ? SQ_BUSY : SQ_IDLE;
                end
                SQ_BUSY: if (op_done) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int BLK_LOG   = 3,
    parameter int OP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [15:0]       bus_rdata
);
    localparam int IDX_W = ADDR_W - 1;

    seq_state_t       seq_state;
    read_mode_t       mode;
    status_t          st;
    flash_op_t        req_op;
    logic             req_valid;
    logic             clear_err;
    logic             seq_err;
    logic             op_done;
    logic [15:0]      rd_word;
    logic [IDX_W-1:0] word_idx;
    logic [15:0]      rdata_q;

    assign word_idx = bus_addr[ADDR_W-1:1];

    fcs_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr_even (!bus_addr[0]),
        .cmd       (bus_wdata[7:0]),
        .op_done   (op_done),
        .state     (seq_state),
        .mode      (mode),
        .req_valid (req_valid),
        .req_op    (req_op),
        .clear_err (clear_err),
        .seq_err   (seq_err)
    );

    fcs_status u_status (
        .clk       (clk),
        .rst       (rst),
        .busy      (seq_state == SQ_BUSY),
        .clear_err (clear_err),
        .seq_err   (seq_err),
        .st        (st)
    );

    fcs_array #(
        .IDX_W     (IDX_W),
        .BLK_LOG   (BLK_LOG),
        .OP_CYCLES (OP_CYCLES)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_idx   (word_idx),
        .req_data  (bus_wdata),
        .rd_idx    (word_idx),
        .rd_word   (rd_word),
        .op_done   (op_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= (mode == RM_ARRAY) ? rd_word : {8'h00, status_byte(st)};
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [15:0]       bus_rdata,
    input seq_state_t        state,
    input read_mode_t        mode,
    input status_t           st,
    input logic              req_valid,
    input logic              op_done
);
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && mode == RM_STATUS) |=> bus_rdata == {8'h00, status_byte($past(st))}); // R4

    AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[0] && state == SQ_IDLE && bus_wdata[7:0] == CMD_CLEAR_ERR)
        |=> (!st.erase_err && !st.prog_err)); // R5

    AST_SEQ_FAULT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[0] && state == SQ_ERASE_ARM && bus_wdata[7:0] != CMD_CONFIRM)
        |=> (st.erase_err && st.prog_err && state == SQ_IDLE && mode == RM_STATUS)); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!st.ready && state == SQ_BUSY)); // R9

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_BUSY && !op_done) |=> (state == SQ_BUSY && mode == RM_STATUS)); // R9

    AST_DONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        op_done |=> (mode == RM_STATUS && st.ready)); // R10

    AST_ODD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[0] && state != SQ_BUSY)
        |=> ($stable(state) && $stable(mode) && $stable(st))); // R11
endmodule

bind flash_cmd_seq fcs_checker #(.ADDR_W(ADDR_W)) u_fcs_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .state     (seq_state),
    .mode      (mode),
    .st        (st),
    .req_valid (req_valid),
    .op_done   (op_done)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int BLK_LOG    = 3;
    localparam int WORDS      = 1 << (ADDR_W - 1);
    localparam int BLK_WORDS  = 1 << BLK_LOG;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [15:0]       bus_rdata;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG), .OP_CYCLES(4)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          checks   = 0;
    int          failures = 0;
    logic [15:0] bmem [WORDS];
    logic        bstatus_mode = 1'b0;
    logic        berr = 1'b0;
    logic [15:0] got;

    function automatic logic [15:0] stat_word(logic ready, logic err);
        return {8'h00, ready, 1'b0, err, err, 4'b0000};
    endfunction

    task automatic check(string tag, logic [15:0] actual, logic [15:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_ready(string tag);
        int n = 0;
        logic [15:0] d;
        rd(0, d);
        while (!d[7] && n < 40) begin
            rd(0, d);
            n++;
        end
        check(tag, d, stat_word(1'b1, berr));
    endtask

    task automatic check_all(string tag);
        logic [15:0] d;
        wr(0, 16'h00FF);
        bstatus_mode = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            rd(ADDR_W'(2 * i), d);
            check(tag, d, bmem[i]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) bmem[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, array mode, erased store
        for (int i = 0; i < WORDS; i++) begin
            rd(ADDR_W'(2 * i), got);
            check("R1 erased word", got, 16'hFFFF);
        end
        wr(0, 16'h0070);
        rd(6, got);
        check("R1 R4 status after reset", got, 16'h0080);

        // R6 R9 R10: program every word
        for (int i = 0; i < WORDS; i++) begin
            logic [15:0] pat = 16'(i * 16'h1357) ^ 16'hA5C3;
            wr(0, 16'h0040);
            wr(ADDR_W'(2 * i), pat);
            bmem[i] = bmem[i] & pat;
            if (i == 0) begin
                rd(10, got);
                check("R9 not ready while busy", got, stat_word(1'b0, 1'b0));
                wr(0, 16'h00FF);
                wait_ready("R10 ready after program");
                rd(4, got);
                check("R9 write during busy ignored", got, stat_word(1'b1, 1'b0));
            end else begin
                wait_ready("R10 ready after program");
            end
        end
        // R6: second pass shows AND behaviour
        for (int i = 0; i < WORDS; i += 3) begin
            logic [15:0] pat = ~(16'(i) << (i % 8));
            wr(0, 16'h7340);
            wr(ADDR_W'(2 * i), pat);
            bmem[i] = bmem[i] & pat;
            wait_ready("R6 ready after reprogram");
        end
        wr(0, 16'h12FF);
        bstatus_mode = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            rd(ADDR_W'(2 * i), got);
            check("R3 R6 programmed word", got, bmem[i]);
        end

        // R7: erase block 1 and block 3 (scrambled high byte)
        wr(0, 16'h0020);
        wr(ADDR_W'(2 * (BLK_WORDS + 5)), 16'h00D0);
        for (int i = BLK_WORDS; i < 2 * BLK_WORDS; i++) bmem[i] = 16'hFFFF;
        wait_ready("R7 R10 erase done");
        wr(0, 16'hC720);
        wr(ADDR_W'(2 * (3 * BLK_WORDS)), 16'hABD0);
        for (int i = 3 * BLK_WORDS; i < 4 * BLK_WORDS; i++) bmem[i] = 16'hFFFF;
        wait_ready("R7 R2 erase done");
        check_all("R7 block erase");

        // R8: aborted erase
        wr(0, 16'h0020);
        wr(4, 16'h00AA);
        berr = 1'b1;
        rd(8, got);
        check("R8 sequence error status", got, 16'h00B0);
        check_all("R8 nothing erased");

        // R5: clear errors keeps array mode
        wr(0, 16'h0050);
        berr = 1'b0;
        rd(2, got);
        check("R5 mode unchanged by clear", got, bmem[1]);
        wr(0, 16'h0070);
        rd(2, got);
        check("R5 errors cleared", got, 16'h0080);

        // R11: odd writes ignored
        wr(1, 16'h00FF);
        rd(6, got);
        check("R11 odd read-array ignored", got, 16'h0080);
        wr(1, 16'h0040);
        wr(2, 16'h0000);
        wr(0, 16'h0020);
        wr(3, 16'h0011);
        rd(0, got);
        check("R11 odd write in erase sequence no error", got, 16'h0080);
        wr(2, 16'h00D0);
        for (int i = 0; i < BLK_WORDS; i++) bmem[i] = 16'hFFFF;
        wait_ready("R11 erase after odd write");
        check_all("R11 program not armed by odd write");

        // R2 R3 R4 R5 R8: sweep every command byte
        wr(0, 16'h0020);
        wr(0, 16'h0011);
        berr = 1'b1;
        bstatus_mode = 1'b1;
        for (int c = 0; c < 256; c++) begin
            logic [7:0] hi = 8'(c) ^ 8'h3C;
            if (c == 8'h40) continue;
            if (c == 8'h20) begin
                wr(0, {hi, 8'h20});
                wr(0, 16'h00C3);
                berr = 1'b1;
                bstatus_mode = 1'b1;
            end else begin
                wr(0, {hi, 8'(c)});
                if (c == 8'hFF) bstatus_mode = 1'b0;
                if (c == 8'h70) bstatus_mode = 1'b1;
                if (c == 8'h50) berr = 1'b0;
            end
            rd(ADDR_W'(2 * (c % WORDS)), got);
            check("R2 command sweep", got,
                  bstatus_mode ? stat_word(1'b1, berr) : bmem[c % WORDS]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule